// File: doc/BRIEF.md
# DMA Window Address Translator

This block turns a device-side DMA bus address into a physical memory address. It holds a small set of programmable windows. Each window has three 64-bit settings: a base word that also carries control bits, a size mask, and a translated base. A translation request presents a bus address. One clock later the block returns the physical address, a hit flag and an error flag. The error flag is raised for windows that are set to page-table (scatter-gather) mode, because that mode is detected and reported but not carried out.

Software sets up the windows through a flat register port. A 4-bit word index selects one of the settings, and reads are combinational. The size mask has two roles. Its set bits in the range 30:20 remove those address bits from the window compare, and the same bits are passed through from the bus address to the output. Windows are searched from the lowest index upward, and the first enabled window whose range matches decides the result.

Top module: `dma_window_xlat`

## Requirements
- R1: After a synchronous active-low reset, all twelve window settings read as zero, and rsp_valid, rsp_hit and rsp_sg_err are low.
- R2: A write with cfg_wen high stores cfg_wdata into the setting chosen by cfg_idx, where cfg_idx[1:0] is the window number and cfg_idx[3:2] is the kind: 0 = base/control, 1 = size mask, 2 = translated base. A later read at the same index returns all 64 bits of the last value written.
- R3: Indices whose kind field is 3 (12 to 15) read as zero, and writes to them change no setting.
- R4: A window's range matches when the bus address equals the window base on every bit in 30:20 whose size-mask bit is clear. Bits 19:0 and bits 63:31 never take part in the compare.
- R5: Bit 0 of the base word enables the window. A matching window whose enable bit is clear is skipped, and the search continues with the next window.
- R6: When the deciding window has base bit 1 (scatter-gather) set, the response has rsp_sg_err=1, rsp_hit=0 and rsp_addr=0.
- R7: On a direct hit, rsp_hit=1, and rsp_addr takes bits 19:0 and the size-mask-set bits of 30:20 from the bus address. Every other bit comes from the translated base.
- R8: When several enabled windows match, the lowest-numbered one decides the result.
- R9: When no enabled window matches, the response has rsp_addr=0, rsp_hit=0 and rsp_sg_err=0.
- R10: A request with req_valid high at clock edge N gives its response, with rsp_valid high, after edge N+1's predecessor registers, that is, in the cycle after the request. A cycle without a request gives rsp_valid, rsp_hit, rsp_sg_err low and rsp_addr zero in the cycle that follows.
- R11: A setting written at one clock edge applies to a request sampled at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wen | input | 1 | Setting write strobe |
| cfg_idx | input | 4 | Setting index {kind, window} |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Read data for cfg_idx (combinational) |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 64 | Physical address (zero on a miss or on a scatter-gather hit) |
| rsp_hit | output | 1 | Direct translation found |
| rsp_sg_err | output | 1 | Deciding window is in scatter-gather mode |

## Verification
The bench builds the block with its default values: four windows and a compare field of bits 30:20. With these values the field has only 2048 codes. For each window layout, every code is swept, and bits 63:31 and 19:0 are varied along with it, so every compare outcome and every pass-through boundary is reached. The layouts cover a reset (all-disabled) state, a mixed layout with a disabled window overlapping an enabled one, a full-mask catch-all window below higher-priority windows, and a layout where every address lands on a scatter-gather window. Expected results come from a bench model of the mask rules, which uses the settings the bench wrote.

// File: rtl/dwt_pkg.sv
// Shared types for the DMA window translator.
// Assumes 64-bit settings and a two-bit kind field in the index.
package dwt_pkg;
    localparam int REG_W  = 64;
    localparam int EN_BIT = 0;
    localparam int SG_BIT = 1;

    typedef enum logic [1:0] {
        KIND_BASE = 2'd0,
        KIND_MASK = 2'd1,
        KIND_XLAT = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] xlat;
    } win_cfg_t;
endpackage

// File: rtl/dwt_cfg_regs.sv
// Window setting storage with a flat index port.
// Index = {kind[1:0], window}. Kind 3 and out-of-range windows are holes:
// reads give zero, writes are dropped. Assumes NUM_WIN >= 2.
module dwt_cfg_regs
    import dwt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int WIN_W   = 2,
    parameter int IDX_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wen,
    input  logic [IDX_W-1:0]     idx,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output win_cfg_t             cfg [NUM_WIN]
);
    reg_kind_e        kind;
    logic [WIN_W-1:0] win;
    logic             win_ok;

    // Split the index into kind and window fields.
    always_comb begin
        kind   = reg_kind_e'(idx[IDX_W-1 -: 2]);
        win    = idx[WIN_W-1:0];
        win_ok = (int'(win) < NUM_WIN);
    end

    win_cfg_t cfg_q [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic sel;
        assign sel = wen && win_ok && (int'(win) == g);

        // Hold one window's three settings; update the addressed one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (sel) begin
                case (kind)
                    KIND_BASE: cfg_q[g].base <= wdata;
                    KIND_MASK: cfg_q[g].mask <= wdata;
                    KIND_XLAT: cfg_q[g].xlat <= wdata;
                    default:   ;
                endcase
            end
        end

        assign cfg[g] = cfg_q[g];

        // Dropped writes and idle cycles leave the window untouched.
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!wen || kind == KIND_NONE || !win_ok || int'(win) != g)
            |=> $stable(cfg_q[g]));
    end

    // Combinational read-back of the addressed setting.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (win_ok && int'(win) == i) begin
                case (kind)
                    KIND_BASE: rdata = cfg_q[i].base;
                    KIND_MASK: rdata = cfg_q[i].mask;
                    KIND_XLAT: rdata = cfg_q[i].xlat;
                    default:   rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dwt_win_match.sv
// One window's compare and direct-map address composition.
// Assumes FIELD_LO <= FIELD_HI < 64; bits below FIELD_LO always pass through.
module dwt_win_match
    import dwt_pkg::*;
#(
    parameter int FIELD_LO = 20,
    parameter int FIELD_HI = 30
) (
    input  win_cfg_t          cfg,
    input  logic [REG_W-1:0]  addr,
    output logic              take,
    output logic              sg,
    output logic [REG_W-1:0]  xaddr
);
    localparam int FIELD_N = FIELD_HI - FIELD_LO + 1;
    localparam logic [REG_W-1:0] FIELD_M =
        ((REG_W'(1) << FIELD_N) - REG_W'(1)) << FIELD_LO;
    localparam logic [REG_W-1:0] LOW_M = (REG_W'(1) << FIELD_LO) - REG_W'(1);

    logic [REG_W-1:0] cmp_m;
    logic [REG_W-1:0] pass_m;

    // Range compare under the inverted size mask, then compose the address.
    always_comb begin
        cmp_m  = ~cfg.mask & FIELD_M;
        pass_m = (cfg.mask & FIELD_M) | LOW_M;
        take   = cfg.base[EN_BIT] && ((addr & cmp_m) == (cfg.base & cmp_m));
        sg     = cfg.base[SG_BIT];
        xaddr  = (cfg.xlat & ~pass_m) | (addr & pass_m);
    end
endmodule

// File: rtl/dwt_first_pick.sv
// Picks the lowest-numbered taking window and forms the raw result.
// Assumes take flags already include the enable bit.
module dwt_first_pick
    import dwt_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic [NUM_WIN-1:0] take,
    input  logic [NUM_WIN-1:0] sg,
    input  logic [REG_W-1:0]   xaddr [NUM_WIN],
    output logic               hit,
    output logic               sg_err,
    output logic [REG_W-1:0]   paddr
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        hit    = 1'b0;
        sg_err = 1'b0;
        paddr  = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (take[i]) begin
                hit    = !sg[i];
                sg_err = sg[i];
                paddr  = sg[i] ? '0 : xaddr[i];
            end
        end
    end
endmodule

// File: rtl/dma_window_xlat.sv
// DMA window translator top: settings, per-window match, priority pick,
// registered response one cycle after each request.
// Assumes NUM_WIN is a power of two, at least 2.
module dma_window_xlat
    import dwt_pkg::*;
#(
    parameter int NUM_WIN  = 4,
    parameter int FIELD_LO = 20,
    parameter int FIELD_HI = 30,
    localparam int WIN_W   = $clog2(NUM_WIN),
    localparam int IDX_W   = WIN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wen,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [63:0]       cfg_wdata,
    output logic [63:0]       cfg_rdata,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_addr,
    output logic              rsp_hit,
    output logic              rsp_sg_err
);
    win_cfg_t           cfg [NUM_WIN];
    logic [NUM_WIN-1:0] take;
    logic [NUM_WIN-1:0] sg;
    logic [REG_W-1:0]   xaddr [NUM_WIN];
    logic               pick_hit;
    logic               pick_sg;
    logic [REG_W-1:0]   pick_addr;

    dwt_cfg_regs #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (cfg_wen),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        dwt_win_match #(.FIELD_LO(FIELD_LO), .FIELD_HI(FIELD_HI)) u_match (
            .cfg   (cfg[g]),
            .addr  (req_addr),
            .take  (take[g]),
            .sg    (sg[g]),
            .xaddr (xaddr[g])
        );
    end

    dwt_first_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .take   (take),
        .sg     (sg),
        .xaddr  (xaddr),
        .hit    (pick_hit),
        .sg_err (pick_sg),
        .paddr  (pick_addr)
    );

    // Register the response; idle cycles clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_hit    <= 1'b0;
            rsp_sg_err <= 1'b0;
        end else begin
            rsp_valid  <= 1'b1;
            rsp_addr   <= pick_addr;
            rsp_hit    <= pick_hit;
            rsp_sg_err <= pick_sg;
        end
    end

    p_follow_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_sg_err));
    p_hit_sg_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_sg_err));
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));
    p_low_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pick_hit) |=> (rsp_addr[FIELD_LO-1:0] == $past(req_addr[FIELD_LO-1:0])));
endmodule

// File: tb/sim_dma_window_xlat.sv
module sim_dma_window_xlat;
    localparam int  CLK_PERIOD = 10;
    localparam int  WD_CYCLES  = 150000;
    localparam logic [63:0] FIELD_M = 64'h0000_0000_7FF0_0000;
    localparam logic [63:0] LOW_M   = 64'h0000_0000_000F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wen = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        rsp_hit;
    logic        rsp_sg_err;

    int nvec = 0;
    int nbad = 0;

    logic [63:0] m_base [4];
    logic [63:0] m_mask [4];
    logic [63:0] m_xlat [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_window_xlat u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_hit(rsp_hit), .rsp_sg_err(rsp_sg_err)
    );

    // Bench model of the window rules (R4..R9).
    function automatic void model(input logic [63:0] a, output logic [63:0] pa,
                                  output logic h, output logic e);
        logic found = 1'b0;
        pa = '0; h = 1'b0; e = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] cm = ~m_mask[i] & FIELD_M;
            logic [63:0] pm = (m_mask[i] & FIELD_M) | LOW_M;
            if (!found && m_base[i][0] && ((a & cm) == (m_base[i] & cm))) begin
                found = 1'b1;
                if (m_base[i][1]) e = 1'b1;
                else begin
                    h = 1'b1;
                    pa = (m_xlat[i] & ~pm) | (a & pm);
                end
            end
        end
    endfunction

    task automatic wr(input int kind, input int win, input logic [63:0] d);
        @(negedge clk);
        cfg_wen = 1'b1; cfg_idx = 4'(kind * 4 + win); cfg_wdata = d;
        if (kind == 0) m_base[win] = d;
        if (kind == 1) m_mask[win] = d;
        if (kind == 2) m_xlat[win] = d;
        @(negedge clk);
        cfg_wen = 1'b0;
    endtask

    task automatic rd_check(input int idx, input logic [63:0] exp, input string tag);
        cfg_idx = 4'(idx);
        #1;
        nvec++;
        if (cfg_rdata !== exp) begin
            nbad++;
            $display("FAIL %s idx=%0d got=%h exp=%h", tag, idx, cfg_rdata, exp);
        end
    endtask

    // Present a request now (at a negedge) and check its response one cycle later.
    task automatic xlate(input logic [63:0] a, input string tag);
        logic [63:0] ep; logic eh; logic ee;
        model(a, ep, eh, ee);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        nvec++;
        if (rsp_valid !== 1'b1 || rsp_addr !== ep || rsp_hit !== eh || rsp_sg_err !== ee) begin
            nbad++;
            $display("FAIL %s/%s a=%h got v=%b pa=%h h=%b e=%b exp v=1 pa=%h h=%b e=%b",
                     tag, ee ? "R6" : (eh ? "R7" : "R9"), a, rsp_valid, rsp_addr,
                     rsp_hit, rsp_sg_err, ep, eh, ee);
        end
    endtask

    task automatic sweep(input int step, input string tag);
        @(negedge clk);
        for (int k = 0; k < 2048; k += step) begin
            logic [32:0] hi = 33'(k * 32'h9E3779B1);
            logic [19:0] lo = 20'(k * 20'h3A5C7);
            xlate({hi, 11'(k), lo}, tag);
        end
        req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_xlat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        nvec++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_sg_err !== 1'b0) begin
            nbad++;
            $display("FAIL R1 rsp v=%b h=%b e=%b exp 0 0 0", rsp_valid, rsp_hit, rsp_sg_err);
        end
        for (int i = 0; i < 16; i++) rd_check(i, '0, "R1");

        // R9/R5: all windows disabled after reset
        sweep(64, "R5");

        // Layout B: direct, wide, disabled overlap, scatter-gather
        wr(0, 0, 64'h0000_0000_0010_0001);
        wr(1, 0, 64'h0);
        wr(2, 0, 64'hABCD_0000_1230_0000);
        wr(0, 1, 64'hFFFF_0000_2000_0001);   // R4: bits above 30 ignored
        wr(1, 1, 64'h0000_0000_0FF0_0000);
        wr(2, 1, 64'h0000_0001_0000_0000);
        wr(0, 2, 64'h0000_0000_0010_0000);   // R5: disabled, overlaps window 0
        wr(1, 2, 64'h0000_0000_7FF0_0000);
        wr(2, 2, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(0, 3, 64'h0000_0000_3000_0003);
        wr(1, 3, 64'h0000_0000_00F0_0000);
        wr(2, 3, 64'h5555_0000_0000_0000);

        // R2: read-back of every written setting
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 4; w++)
                rd_check(k * 4 + w, k == 0 ? m_base[w] : (k == 1 ? m_mask[w] : m_xlat[w]), "R2");

        // R3: holes read zero and drop writes
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            cfg_wen = 1'b1; cfg_idx = 4'(12 + w); cfg_wdata = 64'hDEAD_BEEF_0BAD_F00D;
            @(negedge clk);
            cfg_wen = 1'b0;
            rd_check(12 + w, '0, "R3");
        end
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 4; w++)
                rd_check(k * 4 + w, k == 0 ? m_base[w] : (k == 1 ? m_mask[w] : m_xlat[w]), "R3");

        sweep(1, "R4");

        // R10: idle cycle clears the response
        @(negedge clk);
        nvec++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_sg_err !== 1'b0 || rsp_addr !== '0) begin
            nbad++;
            $display("FAIL R10 idle got v=%b pa=%h h=%b e=%b exp 0", rsp_valid, rsp_addr, rsp_hit, rsp_sg_err);
        end

        // R8: enable the catch-all window 2 underneath
        wr(0, 2, 64'h0000_0000_0000_0001);
        sweep(1, "R8");

        // R11: write then immediate request
        @(negedge clk);
        cfg_wen = 1'b1; cfg_idx = 4'(2 * 4 + 2); cfg_wdata = 64'h0123_4560_0000_0000;
        m_xlat[2] = 64'h0123_4560_0000_0000;
        @(negedge clk);
        cfg_wen = 1'b0;
        xlate(64'h0000_0000_6789_ABCD, "R11");
        req_valid = 1'b0;

        // R6: every address falls on a scatter-gather window
        wr(0, 0, 64'h0000_0000_0000_0003);
        wr(1, 0, 64'h0000_0000_7FF0_0000);
        sweep(1, "R6");

        // R7/R8: window 0 disabled, window 1 full mask takes everything
        wr(0, 0, 64'h0000_0000_0000_0000);
        wr(1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        sweep(1, "R7");

        summary();
    end
endmodule